// File: doc/BRIEF.md
# Waveform-Setting Unlock and Commit Sequencer

This block sits behind a management register interface: a register address, 16-bit write data and a write strobe. It watches writes to a control register for a fixed five-step unlock pattern. Once that pattern is seen, a hidden staging register accepts a new transmit waveform-shaping value. That value becomes the active setting only when a validation code is written to the control register. A later exit code returns the block to normal mode.

The block also holds a fast-transmit mode flag. The flag is set by a mode write to register 0 or by the result of an auto-negotiation. An auto-negotiation pulse restores the active setting to its default and drops any sequence in progress. After such a pulse, software must repeat the whole unlock, stage and validate sequence.

Top module: `shape_unlock_top`

## Requirements
- R1: After reset the active setting is 0x81C8, the unlocked status is 0, the fast-mode flag is 0 and the commit pulse is 0.
- R2: Five writes to register 20 carrying 0x0000, 0x0000, 0x0400, 0x0000, 0x0400, in that order, set unlocked to 1 on the clock edge that takes the fifth write. Writes to other addresses between the steps leave the progress intact.
- R3: A register-20 write that does not match the next expected code discards the progress. If that mismatching value is 0x0000, it counts as the first step of a new attempt.
- R4: While unlocked, a write to register 23 stores the staged value, and the active setting does not change yet.
- R5: While unlocked with a staged value, writing 0x4416 to register 20 makes the staged value active on that edge. The commit pulse is high for exactly the one following cycle.
- R6: Writing 0x4416 with no staged value commits nothing and gives no pulse. The block still moves on to await the exit code, stays unlocked, and there ignores writes to register 23 and further validation codes.
- R7: While awaiting the exit code, writing 0x0000 to register 20 clears unlocked and keeps the active setting.
- R8: A register-23 write while locked is ignored: the active setting is unchanged and nothing is staged for a later validation.
- R9: An auto-negotiation pulse restores 0x81C8, clears the staged value and the pattern progress, and locks the block. It takes priority over a write in the same cycle.
- R10: A write to register 0 sets the fast-mode flag to 1 if the data is 0x2100 and to 0 otherwise. An auto-negotiation pulse loads the flag from the negotiated-speed input.
- R11: While unlocked and before validation, a register-20 write other than 0x4416 locks the block and discards the staged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one register write |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 16 | Write data |
| an_pulse | input | 1 | One-cycle pulse: auto-negotiation has run |
| an_fast | input | 1 | Negotiated speed is 100 Mb/s, sampled with an_pulse |
| shape_value | output | 16 | Active waveform-shaping setting |
| fast_sel | output | 1 | Fast-transmit mode flag |
| unlocked | output | 1 | Hidden register write mode is open |
| commit_pulse | output | 1 | One cycle high after the active setting is updated |

## Verification
Every result here is registered once. The unlocked status, the mode flag, the active setting and the commit pulse all take their new value on the first rising edge that sees the write or the auto-negotiation pulse. The commit pulse drops again one edge later. The bench drives each write on a falling edge and removes it on the next falling edge, then samples at that point: half a cycle after the edge that took the write. To check the one-cycle pulse width, it samples again one falling edge later. For requirements that something is ignored, the bench reads the active setting and the unlocked status right after the stimulus. It then validates, so that a wrongly staged value would appear at the ports.

// File: rtl/shape_unlock_pkg.sv
package shape_unlock_pkg;

   typedef enum logic [1:0] {
      ST_LOCKED = 2'd0,
      ST_OPEN   = 2'd1,
      ST_ARMED  = 2'd2
   } seq_state_e;

   localparam int unsigned DEF_DATA_W = 16;
   localparam int unsigned DEF_ADDR_W = 5;
   localparam int unsigned DEF_STEPS  = 5;

   localparam logic [DEF_DATA_W-1:0] DEF_RESET_VAL = 16'h81C8;
   localparam logic [DEF_DATA_W-1:0] DEF_VALIDATE  = 16'h4416;
   localparam logic [DEF_DATA_W-1:0] DEF_EXIT      = 16'h0000;
   localparam logic [DEF_DATA_W-1:0] DEF_FAST_CODE = 16'h2100;

   // step 0 sits in the low bits
   localparam logic [DEF_STEPS*DEF_DATA_W-1:0] DEF_PATTERN =
      {16'h0400, 16'h0000, 16'h0400, 16'h0000, 16'h0000};

endpackage

// File: rtl/shape_unlock_tracker.sv
module shape_unlock_tracker #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned STEPS  = 5,
   parameter logic [STEPS*DATA_W-1:0] PATTERN = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step_en,
   input  logic [DATA_W-1:0] data,
   output logic              done
);
   localparam int unsigned STEP_W = $clog2(STEPS + 1);
   localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

   if (STEPS < 2) begin : g_bad_steps
      $error("shape_unlock_tracker: STEPS must be at least 2");
   end

   logic [DATA_W-1:0] code_at [STEPS];
   for (genvar gi = 0; gi < STEPS; gi++) begin : g_codes
      assign code_at[gi] = PATTERN[gi*DATA_W +: DATA_W];
   end

   logic [STEP_W-1:0] step_q;
   logic [DATA_W-1:0] expect_code;
   logic              hit;
   logic              restart;

   always_comb begin
      expect_code = code_at[0];
      for (int i = 0; i < STEPS; i++) begin
         if (step_q == STEP_W'(i)) expect_code = code_at[i];
      end
   end

   assign hit     = (data == expect_code);
   assign restart = (data == code_at[0]);
   assign done    = step_en && !clear && hit && (step_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (clear) begin
         step_q <= '0;
      end else if (step_en) begin
         if (hit) begin
            step_q <= (step_q == LAST) ? '0 : step_q + 1'b1;
         end else if (restart) begin
            step_q <= STEP_W'(1);
         end else begin
            step_q <= '0;
         end
      end
   end

   p_step_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step_q <= LAST);

   p_step_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !clear) |=> (step_q <= $past(step_q) + 1'b1));

   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (step_q == '0));

endmodule

// File: rtl/shape_commit_reg.sv
module shape_commit_reg #(
   parameter int unsigned DATA_W = 16,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restore,
   input  logic              flush_stage,
   input  logic              stage_we,
   input  logic [DATA_W-1:0] stage_data,
   input  logic              validate,
   output logic [DATA_W-1:0] active_o,
   output logic              commit_o
);
   if (DATA_W < 1) begin : g_bad_width
      $error("shape_commit_reg: DATA_W must be positive");
   end

   logic [DATA_W-1:0] staged_q;
   logic              staged_vld_q;
   logic [DATA_W-1:0] active_q;
   logic              commit_q;
   logic              do_commit;

   assign do_commit = validate && staged_vld_q && !restore;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         staged_q     <= '0;
         staged_vld_q <= 1'b0;
      end else if (restore || flush_stage || do_commit) begin
         staged_q     <= '0;
         staged_vld_q <= 1'b0;
      end else if (stage_we) begin
         staged_q     <= stage_data;
         staged_vld_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= RESET_VAL;
         commit_q <= 1'b0;
      end else begin
         commit_q <= do_commit;
         if (restore) begin
            active_q <= RESET_VAL;
         end else if (do_commit) begin
            active_q <= staged_q;
         end
      end
   end

   assign active_o = active_q;
   assign commit_o = commit_q;

   p_commit_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> (active_q == $past(staged_q)));

   p_hold_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit_q && !$past(restore)) |-> $stable(active_q));

   p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restore |=> (active_q == RESET_VAL && !staged_vld_q && !commit_q));

endmodule

// File: rtl/shape_mode_sel.sv
module shape_mode_sel #(
   parameter int unsigned DATA_W = 16,
   parameter logic [DATA_W-1:0] FAST_CODE = '0,
   parameter bit AN_LOADS_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [DATA_W-1:0] data,
   input  logic              an_pulse,
   input  logic              an_fast,
   output logic              fast_o
);
   logic fast_q;
   logic an_next;

   if (AN_LOADS_MODE) begin : g_an_load
      assign an_next = an_fast;
   end else begin : g_an_keep
      logic unused_fast;
      assign unused_fast = an_fast;
      assign an_next = fast_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_q <= 1'b0;
      end else if (an_pulse) begin
         fast_q <= an_next;
      end else if (mode_wr) begin
         fast_q <= (data == FAST_CODE);
      end
   end

   assign fast_o = fast_q;

   p_mode_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_wr && !an_pulse) |=> (fast_q == ($past(data) == FAST_CODE)));

endmodule

// File: rtl/shape_unlock_top.sv
module shape_unlock_top
   import shape_unlock_pkg::*;
#(
   parameter int unsigned DATA_W = DEF_DATA_W,
   parameter int unsigned ADDR_W = DEF_ADDR_W,
   parameter int unsigned STEPS  = DEF_STEPS,
   parameter logic [STEPS*DATA_W-1:0] PATTERN = DEF_PATTERN,
   parameter logic [ADDR_W-1:0] MODE_ADDR  = 5'd0,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 5'd20,
   parameter logic [ADDR_W-1:0] STAGE_ADDR = 5'd23,
   parameter logic [DATA_W-1:0] RESET_VAL  = DEF_RESET_VAL,
   parameter logic [DATA_W-1:0] VALIDATE   = DEF_VALIDATE,
   parameter logic [DATA_W-1:0] EXIT_CODE  = DEF_EXIT,
   parameter logic [DATA_W-1:0] FAST_CODE  = DEF_FAST_CODE,
   parameter bit AN_LOADS_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              an_pulse,
   input  logic              an_fast,
   output logic [DATA_W-1:0] shape_value,
   output logic              fast_sel,
   output logic              unlocked,
   output logic              commit_pulse
);
   if (CTRL_ADDR == STAGE_ADDR || CTRL_ADDR == MODE_ADDR) begin : g_bad_map
      $error("shape_unlock_top: register addresses must differ");
   end

   seq_state_e state_q, state_d;
   logic ctrl_wr, stage_wr, mode_wr;
   logic pattern_done, do_validate, do_abort;

   assign ctrl_wr  = wr_en && (wr_addr == CTRL_ADDR);
   assign stage_wr = wr_en && (wr_addr == STAGE_ADDR);
   assign mode_wr  = wr_en && (wr_addr == MODE_ADDR);

   assign do_validate = (state_q == ST_OPEN) && ctrl_wr && (wr_data == VALIDATE) && !an_pulse;
   assign do_abort    = (state_q == ST_OPEN) && ctrl_wr && (wr_data != VALIDATE);

   shape_unlock_tracker #(
      .DATA_W  (DATA_W),
      .STEPS   (STEPS),
      .PATTERN (PATTERN)
   ) u_tracker (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (an_pulse),
      .step_en (ctrl_wr && (state_q == ST_LOCKED)),
      .data    (wr_data),
      .done    (pattern_done)
   );

   shape_commit_reg #(
      .DATA_W    (DATA_W),
      .RESET_VAL (RESET_VAL)
   ) u_commit (
      .clk         (clk),
      .rst_n       (rst_n),
      .restore     (an_pulse),
      .flush_stage (do_abort || do_validate),
      .stage_we    (stage_wr && (state_q == ST_OPEN)),
      .stage_data  (wr_data),
      .validate    (do_validate),
      .active_o    (shape_value),
      .commit_o    (commit_pulse)
   );

   shape_mode_sel #(
      .DATA_W        (DATA_W),
      .FAST_CODE     (FAST_CODE),
      .AN_LOADS_MODE (AN_LOADS_MODE)
   ) u_mode (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_wr  (mode_wr),
      .data     (wr_data),
      .an_pulse (an_pulse),
      .an_fast  (an_fast),
      .fast_o   (fast_sel)
   );

   always_comb begin
      state_d = state_q;
      if (an_pulse) begin
         state_d = ST_LOCKED;
      end else begin
         unique case (state_q)
            ST_LOCKED: if (pattern_done) state_d = ST_OPEN;
            ST_OPEN:   if (ctrl_wr) state_d = (wr_data == VALIDATE) ? ST_ARMED : ST_LOCKED;
            ST_ARMED:  if (ctrl_wr && wr_data == EXIT_CODE) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_LOCKED;
      else        state_q <= state_d;
   end

   assign unlocked = (state_q == ST_OPEN) || (state_q == ST_ARMED);

   p_an_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      an_pulse |=> (!unlocked && shape_value == RESET_VAL));

   p_commit_from_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      commit_pulse |-> $past(state_q == ST_OPEN));

   p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      commit_pulse |=> !commit_pulse);

   p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ARMED && ctrl_wr && wr_data == EXIT_CODE) |=> !unlocked);

   p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
      do_abort |=> (!unlocked && !commit_pulse));

endmodule

// File: tb/shape_unlock_top_tb.sv
module shape_unlock_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        an_pulse = 1'b0;
   logic        an_fast = 1'b0;
   logic [15:0] shape_value;
   logic        fast_sel, unlocked, commit_pulse;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   shape_unlock_top u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data),
      .an_pulse     (an_pulse),
      .an_fast      (an_fast),
      .shape_value  (shape_value),
      .fast_sel     (fast_sel),
      .unlocked     (unlocked),
      .commit_pulse (commit_pulse)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
      check(act == exp, req, act, exp);
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d, input bit an = 1'b0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; an_pulse = an;
      @(negedge clk);
      wr_en = 1'b0; an_pulse = 1'b0;
   endtask

   task automatic an(input bit fast);
      @(negedge clk);
      an_pulse = 1'b1; an_fast = fast;
      @(negedge clk);
      an_pulse = 1'b0;
   endtask

   task automatic unlock_seq();
      wr(20, 16'h0000); wr(20, 16'h0000); wr(20, 16'h0400);
      wr(20, 16'h0000); wr(20, 16'h0400);
   endtask

   task automatic t_reset();
      chk_eq("R1 shape", shape_value, 16'h81C8);
      chk_eq("R1 unlocked", unlocked, 0);
      chk_eq("R1 fast", fast_sel, 0);
      chk_eq("R1 commit", commit_pulse, 0);
   endtask

   task automatic t_full_sequence();
      wr(0, 16'h2100);
      chk_eq("R10 fast set", fast_sel, 1);
      wr(20, 16'h0000); wr(20, 16'h0000);
      wr(0, 16'h2100);                       // other address between steps (R2)
      wr(20, 16'h0400); wr(20, 16'h0000);
      chk_eq("R2 not yet", unlocked, 0);
      wr(20, 16'h0400);
      chk_eq("R2 unlocked", unlocked, 1);
      wr(23, 16'h1234);
      chk_eq("R4 held", shape_value, 16'h81C8);
      chk_eq("R4 no pulse", commit_pulse, 0);
      wr(20, 16'h4416);
      chk_eq("R5 value", shape_value, 16'h1234);
      chk_eq("R5 pulse", commit_pulse, 1);
      @(negedge clk);
      chk_eq("R5 pulse width", commit_pulse, 0);
      wr(20, 16'h0000);
      chk_eq("R7 locked", unlocked, 0);
      chk_eq("R7 kept", shape_value, 16'h1234);
   endtask

   task automatic t_mismatch();
      an(1'b0);
      wr(20, 16'h0000); wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0400);
      wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0000); wr(20, 16'h0400);
      chk_eq("R3 progress lost", unlocked, 0);
      an(1'b0);
      wr(20, 16'h0000); wr(20, 16'h0000); wr(20, 16'h0000);
      wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0000);
      chk_eq("R3 not yet", unlocked, 0);
      wr(20, 16'h0400);
      chk_eq("R3 restart counted", unlocked, 1);
      an(1'b0);
   endtask

   task automatic t_locked_stage();
      an(1'b0);
      wr(23, 16'hBEEF);
      chk_eq("R8 ignored", shape_value, 16'h81C8);
      unlock_seq();
      wr(20, 16'h4416);
      chk_eq("R6 no commit", commit_pulse, 0);
      chk_eq("R8 nothing staged", shape_value, 16'h81C8);
      chk_eq("R6 still unlocked", unlocked, 1);
      wr(23, 16'h5555);
      wr(20, 16'h4416);
      chk_eq("R6 armed ignores", shape_value, 16'h81C8);
      chk_eq("R6 armed no pulse", commit_pulse, 0);
      chk_eq("R6 armed unlocked", unlocked, 1);
      wr(20, 16'h0000);
      chk_eq("R7 exit", unlocked, 0);
   endtask

   task automatic t_autoneg();
      an(1'b0);
      unlock_seq();
      wr(23, 16'h0F0F);
      an(1'b0);
      chk_eq("R9 relocked", unlocked, 0);
      unlock_seq();
      wr(20, 16'h4416);
      chk_eq("R9 stage cleared", shape_value, 16'h81C8);
      wr(20, 16'h0000);
      wr(20, 16'h0000); wr(20, 16'h0000); wr(20, 16'h0400);
      an(1'b0);
      wr(20, 16'h0000); wr(20, 16'h0400);
      chk_eq("R9 progress cleared", unlocked, 0);
      an(1'b0);
      unlock_seq();
      wr(23, 16'hA5A5); wr(20, 16'h4416);
      chk_eq("R9 setup commit", shape_value, 16'hA5A5);
      wr(20, 16'h0000);
      an(1'b1);
      chk_eq("R9 restored", shape_value, 16'h81C8);
      chk_eq("R10 an fast", fast_sel, 1);
      wr(20, 16'h0000); wr(20, 16'h0000); wr(20, 16'h0400); wr(20, 16'h0000);
      wr(20, 16'h0400, 1'b1);
      chk_eq("R9 priority", unlocked, 0);
   endtask

   task automatic t_abort();
      an(1'b0);
      unlock_seq();
      wr(23, 16'h7777);
      wr(20, 16'h0400);
      chk_eq("R11 aborted", unlocked, 0);
      unlock_seq();
      wr(20, 16'h4416);
      chk_eq("R11 stage dropped", shape_value, 16'h81C8);
      chk_eq("R11 no pulse", commit_pulse, 0);
      wr(20, 16'h0000);
   endtask

   task automatic t_mode();
      wr(0, 16'h2100);
      chk_eq("R10 set", fast_sel, 1);
      wr(0, 16'h1100);
      chk_eq("R10 cleared", fast_sel, 0);
      an(1'b1);
      chk_eq("R10 an load", fast_sel, 1);
      an(1'b0);
      chk_eq("R10 an clear", fast_sel, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_sequence();
      t_mismatch();
      t_locked_stage();
      t_autoneg();
      t_abort();
      t_mode();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule